// File: doc/BRIEF.md
# Bridge Target Termination Selector

This block sits on the target side of a two-interface bridge. For every transaction the bridge receives as a target, it chooses how the bridge answers: it waits, accepts and transfers data, disconnects after the data, retries without taking data, or aborts. The choice is made each clock from the transaction class, the lock state of the transaction and of the bridge, buffer-space and completion flags from the queues, address-boundary and data-exhaustion flags, and the completion status the far-side target reported. The signaling logic of the bus, the data buffers and configuration space are not part of the block, and every condition flag is taken as an ideal input.

A transaction begins with a one-cycle `txn_start` pulse. Its class, lock attribute and originating interface are captured on that cycle. The block then issues one registered termination code per clock until it issues a terminal code (disconnect, retry or abort), after which it returns to idle. An acceptance timer bounds how long an initiator waits for the first data phase. A sticky status bit for each interface records that the bridge signaled a target abort toward that interface. Software clears the bit by writing a one to it.

Top module: `tgt_term_select`

## Requirements
- R1: After synchronous reset, `term_code` is 0 (idle) and every `sta_abort` bit is 0.
- R2: A far-side target abort gives code 5 (abort), and this overrides every retry and disconnect condition. Each code appears on `term_code` one clock after the inputs that caused it.
- R3: Issuing code 5 sets the `sta_abort` bit indexed by the interface captured at `txn_start` (0 or 1). No other bit changes, and the bit stays set after the transaction ends.
- R4: A one on `sta_clr[i]` clears `sta_abort[i]` on the next clock. If an abort on that interface occurs in the same clock, the set wins.
- R5: A posted write (class 0) gives code 4 (retry) when `pw_free_slots` is below 2, which is one slot for the address plus one DWORD. It is accepted (code 2) when 2 or more slots are free.
- R6: While `lock_seq_active` is high, any transaction with `txn_locked` low is retried. A locked transaction is not retried for this reason.
- R7: While `tgt_bus_locked` is high, a locked write (class 0 or 2) is retried. A locked read (class 1) or an unlocked write is not retried for this reason.
- R8: A delayed read (class 1) or delayed write (class 2) is retried while `dly_cpl_ready` is low. A delayed read is also retried while `rd_discarding` is high. Posted writes ignore both flags.
- R9: If `xfer_ready` stays low, a new transaction gets code 1 (wait) for at most 16 clocks. The next clock gives code 4.
- R10: Code 3 (disconnect) is given on `at_addr_boundary`, on `wr_space_exhausted` for a write, or on `rd_data_exhausted` for a read. A read ignores `wr_space_exhausted`, and a write ignores `rd_data_exhausted`.
- R11: Before the first accept, retry takes priority over disconnect. After the first accept, retry conditions and the timer are ignored, and a low `xfer_ready` gives code 1 with no time limit.
- R12: After a terminal code (3, 4 or 5), the next code is 0 unless a new `txn_start` occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | First cycle of a new target transaction |
| txn_kind | input | 2 | Class: 0 posted write, 1 delayed read, 2 delayed write |
| txn_locked | input | 1 | Transaction belongs to a locked sequence |
| txn_side | input | SIDE_W | Interface the initiator sits on |
| lock_seq_active | input | 1 | A locked sequence is being propagated across the bridge |
| tgt_bus_locked | input | 1 | The destination bus is currently locked |
| pw_free_slots | input | PW_FREE_W | Free entries in the posted-write buffer |
| dly_cpl_ready | input | 1 | Delayed completion is queued and at the head |
| rd_discarding | input | 1 | Stale prefetched read data is being flushed |
| xfer_ready | input | 1 | Bridge can take or give data this clock |
| at_addr_boundary | input | 1 | Internal address boundary reached |
| wr_space_exhausted | input | 1 | No room for more write data |
| rd_data_exhausted | input | 1 | No more read data to deliver |
| far_target_abort | input | 1 | Far-side target ended the transaction with an abort |
| sta_clr | input | SIDES | Write-one-to-clear strobes for the abort status bits |
| term_code | output | 3 | 0 idle, 1 wait, 2 accept, 3 disconnect, 4 retry, 5 abort |
| sta_abort | output | SIDES | Sticky signaled-target-abort bit for each interface |

## Verification
The hardest state to reach is the edge of the acceptance window. The timer has to reach its limit with nothing else ending the transaction, and an accept that arrives on the last allowed clock must cancel the limit for the rest of the transfer. The bench holds `xfer_ready` low and every retry and disconnect flag quiet for exactly sixteen clocks, and checks that the next code is a retry. It then repeats the run, raises `xfer_ready` on the sixteenth clock, and holds it low for more than twice the window, expecting only wait codes. A separate case presents an abort and a status clear for the same interface in one clock, to check the set-over-clear ordering.

// File: rtl/tts_pkg.sv
package tts_pkg;

  typedef enum logic [2:0] {
    TERM_IDLE       = 3'd0,
    TERM_WAIT       = 3'd1,
    TERM_ACCEPT     = 3'd2,
    TERM_DISCONNECT = 3'd3,
    TERM_RETRY      = 3'd4,
    TERM_ABORT      = 3'd5
  } term_e;

  typedef enum logic [1:0] {
    KIND_POSTED_WR  = 2'd0,
    KIND_DELAYED_RD = 2'd1,
    KIND_DELAYED_WR = 2'd2
  } kind_e;

  function automatic logic is_terminal(input term_e t);
    return (t == TERM_DISCONNECT) || (t == TERM_RETRY) || (t == TERM_ABORT);
  endfunction

endpackage

// File: rtl/tts_cond_eval.sv
module tts_cond_eval #(
  parameter int PW_FREE_W    = 6,
  parameter int PW_MIN_SLOTS = 2
) (
  input  logic [1:0]           kind,
  input  logic                 locked,
  input  logic                 lock_seq_active,
  input  logic                 tgt_bus_locked,
  input  logic [PW_FREE_W-1:0] pw_free_slots,
  input  logic                 dly_cpl_ready,
  input  logic                 rd_discarding,
  input  logic                 at_addr_boundary,
  input  logic                 wr_space_exhausted,
  input  logic                 rd_data_exhausted,
  output logic                 retry_req,
  output logic                 disc_req
);
  import tts_pkg::*;

  localparam logic [PW_FREE_W-1:0] MIN_SLOTS = PW_FREE_W'(PW_MIN_SLOTS);

  logic is_read, is_write, is_posted, is_delayed;
  logic r_lock_prop, r_tgt_lock, r_pw_space, r_dly_cpl, r_discard;

  always_comb begin
    is_read    = (kind == KIND_DELAYED_RD);
    is_write   = !is_read;
    is_posted  = (kind == KIND_POSTED_WR);
    is_delayed = !is_posted;

    // independent retry causes, ordered only by the caller
    r_lock_prop = lock_seq_active && !locked;
    r_tgt_lock  = tgt_bus_locked && locked && is_write;
    r_pw_space  = is_posted && (pw_free_slots < MIN_SLOTS);
    r_dly_cpl   = is_delayed && !dly_cpl_ready;
    r_discard   = is_read && rd_discarding;

    retry_req = r_lock_prop | r_tgt_lock | r_pw_space | r_dly_cpl | r_discard;

    disc_req  = at_addr_boundary
              | (is_write && wr_space_exhausted)
              | (is_read  && rd_data_exhausted);
  end

endmodule

// File: rtl/tts_accept_timer.sv
module tts_accept_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  input  logic count_en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_eff;

  always_comb begin
    cnt_eff = start ? '0 : cnt_q;
    expired = active && (cnt_eff >= LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (active && count_en && !expired) begin
      cnt_q <= cnt_eff + 1'b1;
    end else begin
      cnt_q <= cnt_eff;
    end
  end

endmodule

// File: rtl/tts_abort_status.sv
module tts_abort_status #(
  parameter int SIDES  = 2,
  parameter int SIDE_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [SIDE_W-1:0] set_idx,
  input  logic [SIDES-1:0]  clr,
  output logic [SIDES-1:0]  status
);

  for (genvar g = 0; g < SIDES; g++) begin : g_bit
    logic hit;
    assign hit = set_en && (set_idx == SIDE_W'(g));
    always_ff @(posedge clk) begin
      if (rst)            status[g] <= 1'b0;
      else if (hit)       status[g] <= 1'b1;
      else if (clr[g])    status[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/tgt_term_select.sv
module tgt_term_select #(
  parameter int ACCEPT_LIMIT = 16,
  parameter int PW_FREE_W    = 6,
  parameter int PW_MIN_SLOTS = 2,
  parameter int SIDES        = 2,
  parameter int SIDE_W       = (SIDES > 1) ? $clog2(SIDES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 txn_start,
  input  logic [1:0]           txn_kind,
  input  logic                 txn_locked,
  input  logic [SIDE_W-1:0]    txn_side,
  input  logic                 lock_seq_active,
  input  logic                 tgt_bus_locked,
  input  logic [PW_FREE_W-1:0] pw_free_slots,
  input  logic                 dly_cpl_ready,
  input  logic                 rd_discarding,
  input  logic                 xfer_ready,
  input  logic                 at_addr_boundary,
  input  logic                 wr_space_exhausted,
  input  logic                 rd_data_exhausted,
  input  logic                 far_target_abort,
  input  logic [SIDES-1:0]     sta_clr,
  output logic [2:0]           term_code,
  output logic [SIDES-1:0]     sta_abort
);
  import tts_pkg::*;

  // captured transaction attributes
  logic              busy_q, accepted_q;
  logic [1:0]        kind_q;
  logic              locked_q;
  logic [SIDE_W-1:0] side_q;

  logic              active, acc_eff;
  logic [1:0]        kind_c;
  logic              locked_c;
  logic [SIDE_W-1:0] side_c;

  logic  retry_req, disc_req, expired, count_en;
  term_e decision, term_q;

  always_comb begin
    active   = txn_start || busy_q;
    acc_eff  = txn_start ? 1'b0 : accepted_q;
    kind_c   = txn_start ? txn_kind   : kind_q;
    locked_c = txn_start ? txn_locked : locked_q;
    side_c   = txn_start ? txn_side   : side_q;
  end

  tts_cond_eval #(
    .PW_FREE_W   (PW_FREE_W),
    .PW_MIN_SLOTS(PW_MIN_SLOTS)
  ) u_cond (
    .kind              (kind_c),
    .locked            (locked_c),
    .lock_seq_active   (lock_seq_active),
    .tgt_bus_locked    (tgt_bus_locked),
    .pw_free_slots     (pw_free_slots),
    .dly_cpl_ready     (dly_cpl_ready),
    .rd_discarding     (rd_discarding),
    .at_addr_boundary  (at_addr_boundary),
    .wr_space_exhausted(wr_space_exhausted),
    .rd_data_exhausted (rd_data_exhausted),
    .retry_req         (retry_req),
    .disc_req          (disc_req)
  );

  // a clock counts toward the window only when nothing else would end it
  assign count_en = !acc_eff && !far_target_abort && !retry_req &&
                    !disc_req && !xfer_ready;

  tts_accept_timer #(.LIMIT(ACCEPT_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (txn_start),
    .active  (active),
    .count_en(count_en),
    .expired (expired)
  );

  always_comb begin
    if (!active)                                   decision = TERM_IDLE;
    else if (far_target_abort)                     decision = TERM_ABORT;
    else if (!acc_eff && (retry_req || expired))   decision = TERM_RETRY;
    else if (disc_req)                             decision = TERM_DISCONNECT;
    else if (xfer_ready)                           decision = TERM_ACCEPT;
    else                                           decision = TERM_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      accepted_q <= 1'b0;
      kind_q     <= '0;
      locked_q   <= 1'b0;
      side_q     <= '0;
      term_q     <= TERM_IDLE;
    end else begin
      term_q <= decision;
      if (txn_start) begin
        kind_q   <= txn_kind;
        locked_q <= txn_locked;
        side_q   <= txn_side;
      end
      busy_q     <= active && !is_terminal(decision);
      accepted_q <= acc_eff || (decision == TERM_ACCEPT);
    end
  end

  tts_abort_status #(.SIDES(SIDES), .SIDE_W(SIDE_W)) u_status (
    .clk    (clk),
    .rst    (rst),
    .set_en (decision == TERM_ABORT),
    .set_idx(side_c),
    .clr    (sta_clr),
    .status (sta_abort)
  );

  assign term_code = term_q;

endmodule

// File: rtl/tts_checker.sv
module tts_checker #(
  parameter int ACCEPT_LIMIT = 16,
  parameter int PW_FREE_W    = 6,
  parameter int PW_MIN_SLOTS = 2,
  parameter int SIDES        = 2,
  parameter int SIDE_W       = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 txn_start,
  input logic [1:0]           txn_kind,
  input logic [SIDE_W-1:0]    txn_side,
  input logic [PW_FREE_W-1:0] pw_free_slots,
  input logic                 far_target_abort,
  input logic [SIDES-1:0]     sta_clr,
  input logic [2:0]           term_code,
  input logic [SIDES-1:0]     sta_abort
);
  localparam int CW = $clog2(ACCEPT_LIMIT + 2);

  logic          start_d, acc_seen;
  logic [CW-1:0] wait_run;
  logic          acc_eff, term_terminal;

  assign acc_eff       = start_d ? 1'b0 : acc_seen;
  assign term_terminal = (term_code == 3'd3) || (term_code == 3'd4) ||
                         (term_code == 3'd5);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_d  <= 1'b0;
      acc_seen <= 1'b0;
      wait_run <= '0;
    end else begin
      start_d  <= txn_start;
      acc_seen <= acc_eff || (term_code == 3'd2);
      if (term_code == 3'd1 && !acc_eff)
        wait_run <= start_d ? CW'(1) : ((wait_run > CW'(ACCEPT_LIMIT)) ? wait_run : wait_run + 1'b1);
      else
        wait_run <= '0;
    end
  end

  assert_abort_first_R2: assert property (@(posedge clk) disable iff (rst)
    (txn_start && far_target_abort) |=> (term_code == 3'd5));

  assert_abort_sets_side0_R3: assert property (@(posedge clk) disable iff (rst)
    (txn_start && far_target_abort && txn_side == '0) |=> sta_abort[0]);

  assert_clear_only_by_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sta_abort[0]) |-> $past(sta_clr[0]));

  assert_pw_space_retry_R5: assert property (@(posedge clk) disable iff (rst)
    (txn_start && txn_kind == 2'd0 && !far_target_abort &&
     pw_free_slots < PW_FREE_W'(PW_MIN_SLOTS)) |=> (term_code == 3'd4));

  assert_wait_window_R9: assert property (@(posedge clk) disable iff (rst)
    wait_run <= CW'(ACCEPT_LIMIT));

  assert_idle_after_end_R12: assert property (@(posedge clk) disable iff (rst)
    (term_terminal && !txn_start) |=> (term_code == 3'd0));

endmodule

bind tgt_term_select tts_checker #(
  .ACCEPT_LIMIT(ACCEPT_LIMIT),
  .PW_FREE_W   (PW_FREE_W),
  .PW_MIN_SLOTS(PW_MIN_SLOTS),
  .SIDES       (SIDES),
  .SIDE_W      (SIDE_W)
) u_tts_checker (
  .clk             (clk),
  .rst             (rst),
  .txn_start       (txn_start),
  .txn_kind        (txn_kind),
  .txn_side        (txn_side),
  .pw_free_slots   (pw_free_slots),
  .far_target_abort(far_target_abort),
  .sta_clr         (sta_clr),
  .term_code       (term_code),
  .sta_abort       (sta_abort)
);

// File: tb/test_tgt_term_select.sv
module test_tgt_term_select;

  localparam int SIDES = 2;
  localparam int LIM   = 16;

  localparam logic [2:0] C_IDLE = 3'd0, C_WAIT = 3'd1, C_ACC = 3'd2,
                         C_DISC = 3'd3, C_RETRY = 3'd4, C_ABORT = 3'd5;

  logic clk = 1'b0;
  logic rst;
  logic txn_start;
  logic [1:0] txn_kind;
  logic txn_locked;
  logic [0:0] txn_side;
  logic lock_seq_active, tgt_bus_locked;
  logic [5:0] pw_free_slots;
  logic dly_cpl_ready, rd_discarding, xfer_ready;
  logic at_addr_boundary, wr_space_exhausted, rd_data_exhausted;
  logic far_target_abort;
  logic [SIDES-1:0] sta_clr;
  logic [2:0] term_code;
  logic [SIDES-1:0] sta_abort;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tgt_term_select i_tgt_term_select (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_kind(txn_kind),
    .txn_locked(txn_locked), .txn_side(txn_side),
    .lock_seq_active(lock_seq_active), .tgt_bus_locked(tgt_bus_locked),
    .pw_free_slots(pw_free_slots), .dly_cpl_ready(dly_cpl_ready),
    .rd_discarding(rd_discarding), .xfer_ready(xfer_ready),
    .at_addr_boundary(at_addr_boundary), .wr_space_exhausted(wr_space_exhausted),
    .rd_data_exhausted(rd_data_exhausted), .far_target_abort(far_target_abort),
    .sta_clr(sta_clr), .term_code(term_code), .sta_abort(sta_abort)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs change 1 ns after an edge; outputs are read there too
  task automatic step();
    @(posedge clk); #1;
    txn_start = 1'b0;
    sta_clr   = '0;
  endtask

  task automatic quiet();
    txn_start = 0; txn_kind = 2'd0; txn_locked = 0; txn_side = 0;
    lock_seq_active = 0; tgt_bus_locked = 0; pw_free_slots = 6'd8;
    dly_cpl_ready = 1; rd_discarding = 0; xfer_ready = 1;
    at_addr_boundary = 0; wr_space_exhausted = 0; rd_data_exhausted = 0;
    far_target_abort = 0; sta_clr = '0;
  endtask

  // start one transaction and return the code it gets on its first clock
  task automatic begin_txn(input logic [1:0] k, input logic lk, output logic [2:0] code);
    txn_kind = k; txn_locked = lk; txn_start = 1'b1;
    step();
    code = term_code;
  endtask

  // end whatever is running with a disconnect and settle to idle
  task automatic close_out();
    at_addr_boundary = 1; step(); at_addr_boundary = 0; step();
  endtask

  task automatic t_reset();
    rst = 1; quiet(); step(); step();
    chk("R1 code", term_code, C_IDLE);
    chk("R1 status", sta_abort, 0);
    rst = 0; step();
    chk("R1 idle after release", term_code, C_IDLE);
  endtask

  task automatic t_pw_space();
    logic [2:0] c;
    quiet(); pw_free_slots = 6'd1;
    begin_txn(2'd0, 0, c); chk("R5 one slot retried", c, C_RETRY);
    step(); chk("R12 idle after retry", term_code, C_IDLE);
    pw_free_slots = 6'd0;
    begin_txn(2'd0, 0, c); chk("R5 zero slots retried", c, C_RETRY);
    step();
    pw_free_slots = 6'd2;
    begin_txn(2'd0, 0, c); chk("R5 two slots accepted", c, C_ACC);
    at_addr_boundary = 1; step(); chk("R10 boundary disconnect", term_code, C_DISC);
    at_addr_boundary = 0; step(); chk("R12 idle after disconnect", term_code, C_IDLE);
  endtask

  task automatic t_lock_prop();
    logic [2:0] c;
    quiet(); lock_seq_active = 1;
    begin_txn(2'd1, 0, c); chk("R6 unlocked read retried", c, C_RETRY);
    step();
    begin_txn(2'd0, 0, c); chk("R6 unlocked write retried", c, C_RETRY);
    step();
    begin_txn(2'd1, 1, c); chk("R6 locked read accepted", c, C_ACC);
    close_out();
  endtask

  task automatic t_tgt_locked();
    logic [2:0] c;
    quiet(); tgt_bus_locked = 1;
    begin_txn(2'd0, 1, c); chk("R7 locked posted write retried", c, C_RETRY);
    step();
    begin_txn(2'd2, 1, c); chk("R7 locked delayed write retried", c, C_RETRY);
    step();
    begin_txn(2'd1, 1, c); chk("R7 locked read accepted", c, C_ACC);
    close_out();
    begin_txn(2'd0, 0, c); chk("R7 unlocked write accepted", c, C_ACC);
    close_out();
  endtask

  task automatic t_delayed();
    logic [2:0] c;
    quiet(); dly_cpl_ready = 0;
    begin_txn(2'd1, 0, c); chk("R8 read without completion", c, C_RETRY);
    step();
    begin_txn(2'd2, 0, c); chk("R8 write without completion", c, C_RETRY);
    step();
    begin_txn(2'd0, 0, c); chk("R8 posted write ignores completion", c, C_ACC);
    close_out();
    dly_cpl_ready = 1; rd_discarding = 1;
    begin_txn(2'd1, 0, c); chk("R8 read while discarding", c, C_RETRY);
    step();
    begin_txn(2'd2, 0, c); chk("R8 write ignores discard", c, C_ACC);
    close_out();
  endtask

  task automatic t_timeout();
    logic [2:0] c;
    quiet(); xfer_ready = 0;
    begin_txn(2'd0, 0, c); chk("R9 first clock waits", c, C_WAIT);
    for (int i = 2; i <= LIM; i++) begin
      step();
      if (i == LIM) chk("R9 sixteenth clock waits", term_code, C_WAIT);
    end
    step(); chk("R9 window expired", term_code, C_RETRY);
    step(); chk("R12 idle after timeout", term_code, C_IDLE);
    // accept on the last allowed clock, then wait without limit
    begin_txn(2'd0, 0, c);
    for (int i = 2; i < LIM; i++) step();
    xfer_ready = 1; step(); chk("R9 accept on clock sixteen", term_code, C_ACC);
    xfer_ready = 0;
    for (int i = 0; i < 2 * LIM + 3; i++) step();
    chk("R11 no limit after accept", term_code, C_WAIT);
    close_out();
  endtask

  task automatic t_disconnect();
    logic [2:0] c;
    quiet();
    begin_txn(2'd0, 0, c); chk("R10 write accepted", c, C_ACC);
    wr_space_exhausted = 1; step(); chk("R10 write space gone", term_code, C_DISC);
    wr_space_exhausted = 0; step();
    begin_txn(2'd1, 0, c);
    rd_data_exhausted = 1; step(); chk("R10 read data gone", term_code, C_DISC);
    step();
    begin_txn(2'd0, 0, c);
    step(); chk("R10 write ignores read flag", term_code, C_ACC);
    rd_data_exhausted = 0; wr_space_exhausted = 1;
    begin_txn(2'd1, 0, c); chk("R10 read ignores write flag", c, C_ACC);
    wr_space_exhausted = 0;
    close_out();
  endtask

  task automatic t_after_accept();
    logic [2:0] c;
    quiet(); pw_free_slots = 6'd0; at_addr_boundary = 1;
    begin_txn(2'd0, 0, c); chk("R11 retry over disconnect", c, C_RETRY);
    at_addr_boundary = 0; pw_free_slots = 6'd8; step();
    begin_txn(2'd0, 0, c); chk("R11 accepted", c, C_ACC);
    pw_free_slots = 6'd0; lock_seq_active = 1; step();
    chk("R11 retry causes ignored after accept", term_code, C_ACC);
    lock_seq_active = 0; pw_free_slots = 6'd8;
    close_out();
  endtask

  task automatic t_abort();
    logic [2:0] c;
    quiet(); txn_side = 1; far_target_abort = 1; lock_seq_active = 1; at_addr_boundary = 1;
    begin_txn(2'd1, 0, c); chk("R2 abort over retry", c, C_ABORT);
    chk("R3 side one bit", sta_abort, 2'b10);
    far_target_abort = 0; lock_seq_active = 0; at_addr_boundary = 0; step();
    chk("R12 idle after abort", term_code, C_IDLE);
    chk("R3 bit stays set", sta_abort, 2'b10);
    txn_side = 0;
    begin_txn(2'd0, 0, c); chk("R3 accepted before abort", c, C_ACC);
    txn_side = 1;  // input ignored mid-transaction; captured side is 0
    far_target_abort = 1; step(); chk("R2 abort mid transfer", term_code, C_ABORT);
    chk("R3 captured side set", sta_abort, 2'b11);
    far_target_abort = 0;
    sta_clr = 2'b10; step(); chk("R4 clear side one", sta_abort, 2'b01);
    txn_side = 0; far_target_abort = 1; sta_clr = 2'b01; txn_kind = 2'd0; txn_start = 1;
    step(); chk("R4 set wins over clear", sta_abort, 2'b01);
    far_target_abort = 0; step();
    sta_clr = 2'b01; step(); chk("R4 clear side zero", sta_abort, 2'b00);
  endtask

  initial begin
    t_reset();
    t_pw_space();
    t_lock_prop();
    t_tgt_locked();
    t_delayed();
    t_timeout();
    t_disconnect();
    t_after_accept();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule